// File: doc/BRIEF.md
# Dual Chip-Select Host Bus Address Decoder

This block sits at the front of a host-bus style external memory interface. Each cycle it takes a bus address with a valid strobe. It decides which of two active-low external chip selects the access belongs to, or whether the access belongs to neither. The decision depends on a 3-bit chip-select mode field and on two region selectors, one for a peripheral window and one for a memory window.

When only one region is enabled in a dual mode, the two chip selects share that region. The region's top offset bit divides it between them. When both regions are enabled, each chip select owns one whole region. In single-device modes only chip select 0 is ever driven.

Along with the chip select, the block chooses the timing profile for the access: clock divisor, wait states for the access direction, and strobe polarity. It also produces the external address, trimmed to the width that the mode leaves free. All outputs are registered and appear one clock after the address is sampled.

Top module: `hb_dcs_decoder`

## Requirements
- R1: While synchronous reset is high, and on the first cycle after it, `cs0_n` and `cs1_n` are 1, `hit` is 0, and `ext_addr`, `prof_clkdiv`, `prof_wait` and `prof_strb_pol` are 0.
- R2: Address bits [31:28] select a window. A nonzero peripheral selector s enables window 0x9+s (s=1 gives 0xA, s=3 gives 0xC). A nonzero memory selector s enables window 0x5+s (s=1 gives 0x6, s=2 gives 0x7). Results appear on the outputs on the rising edge after the address is sampled. When `addr_valid` is 0, the next cycle shows no chip select and `hit`=0.
- R3: When `cs_mode` is neither 2 nor 3, an address in any enabled window asserts `cs0_n` only, and `cs1_n` stays 1.
- R4: When `cs_mode` is 2 or 3 and only the peripheral region is enabled, an address in that window asserts `cs0_n` if address bit 27 is 0, and `cs1_n` if bit 27 is 1.
- R5: When `cs_mode` is 2 or 3 and only the memory region is enabled, its window is split on address bit 27 in the same way as in R4.
- R6: When `cs_mode` is 2 or 3 and both regions are enabled, the peripheral window asserts `cs0_n` and the memory window asserts `cs1_n`, whatever the value of bit 27.
- R7: An address outside every enabled window, or any address when both selectors are 0, asserts neither chip select and gives `hit`=0.
- R8: `cs0_n` and `cs1_n` are never 0 together. `hit` is 1 exactly when one of them is 0.
- R9: A `cs1_n` access uses profile 1 (`t1_*`) only when `cs_own_timing`=1. In every other case a hit uses profile 0 (`t0_*`).
- R10: `prof_wait` is the selected profile's write wait count when `acc_write`=1, and its read wait count otherwise.
- R11: On a hit, `ext_addr` is address bits [27:0] kept to 28 bits for single modes, 27 bits for mode 2 and 26 bits for mode 3. On a miss, `ext_addr` and all profile outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr_valid | input | 1 | Address is valid this cycle |
| addr | input | 32 | Bus address |
| acc_write | input | 1 | 1 for a write access, 0 for a read access |
| cs_mode | input | 3 | Chip-select mode; 2 and 3 are the dual modes |
| peri_sel | input | 2 | Peripheral window selector, 0 disables |
| mem_sel | input | 2 | Memory window selector, 0 disables |
| cs_own_timing | input | 1 | Chip select 1 uses its own timing profile |
| t0_clkdiv | input | 8 | Profile 0 clock divisor |
| t0_rd_ws | input | 2 | Profile 0 read wait states |
| t0_wr_ws | input | 2 | Profile 0 write wait states |
| t0_strb_pol | input | 1 | Profile 0 strobe polarity |
| t1_clkdiv | input | 8 | Profile 1 clock divisor |
| t1_rd_ws | input | 2 | Profile 1 read wait states |
| t1_wr_ws | input | 2 | Profile 1 write wait states |
| t1_strb_pol | input | 1 | Profile 1 strobe polarity |
| cs0_n | output | 1 | Chip select 0, active low |
| cs1_n | output | 1 | Chip select 1, active low |
| hit | output | 1 | Access decoded to a chip select |
| ext_addr | output | 28 | External address, trimmed to the mode width |
| prof_clkdiv | output | 8 | Clock divisor of the chosen profile |
| prof_wait | output | 2 | Wait states for this access direction |
| prof_strb_pol | output | 1 | Strobe polarity of the chosen profile |

## Verification
Two cases are hard to reach: a dual mode with both windows enabled, where address bit 27 is set inside the peripheral window, and a chip select 1 access with separate timing turned off. In both, a wrong decoder still produces a plausible chip select or profile, so the error does not show unless the stimulus is built for it. Each directed scenario first programs the mode and selectors, then sends addresses that sit on either side of bit 27 and inside and outside each window. The two timing profiles use values that differ in every field, so a wrong profile or a wrong direction choice shows on the outputs.

// File: rtl/hb_dcs_pkg.sv
package hb_dcs_pkg;

    localparam int DIV_W = 8;
    localparam int WS_W  = 2;

    typedef struct packed {
        logic [DIV_W-1:0] clkdiv;
        logic [WS_W-1:0]  rd_ws;
        logic [WS_W-1:0]  wr_ws;
        logic             strb_pol;
    } timing_prof_t;

    typedef struct packed {
        logic [DIV_W-1:0] clkdiv;
        logic [WS_W-1:0]  wait_cnt;
        logic             strb_pol;
    } access_timing_t;

    typedef enum logic [1:0] {
        CS_NONE = 2'd0,
        CS_ZERO = 2'd1,
        CS_ONE  = 2'd2
    } cs_choice_t;

    function automatic logic mode_is_dual(input logic [2:0] mode);
        return (mode == 3'd2) || (mode == 3'd3);
    endfunction

endpackage

// File: rtl/hb_region_match.sv
module hb_region_match #(
    parameter int WIN_W    = 4,
    parameter int SEL_W    = 2,
    parameter int WIN_BASE = 10
) (
    input  logic [WIN_W-1:0] win,
    input  logic [SEL_W-1:0] sel,
    output logic             enabled,
    output logic             match
);
    logic [WIN_W-1:0] target;

    always_comb begin
        target  = WIN_W'(WIN_BASE) + WIN_W'(sel) - WIN_W'(1);
        enabled = (sel != '0);
        match   = enabled && (win == target);
    end
endmodule

// File: rtl/hb_cs_select.sv
module hb_cs_select
    import hb_dcs_pkg::*;
(
    input  logic       valid,
    input  logic       dual,
    input  logic       peri_en,
    input  logic       mem_en,
    input  logic       peri_hit,
    input  logic       mem_hit,
    input  logic       split_bit,
    output cs_choice_t choice
);
    cs_choice_t half_pick;

    always_comb begin
        half_pick = split_bit ? CS_ONE : CS_ZERO;
        choice    = CS_NONE;
        if (valid) begin
            if (!dual) begin
                if (peri_hit || mem_hit) choice = CS_ZERO;
            end else if (peri_en && mem_en) begin
                if (peri_hit)     choice = CS_ZERO;
                else if (mem_hit) choice = CS_ONE;
            end else if (peri_en) begin
                if (peri_hit) choice = half_pick;
            end else if (mem_en) begin
                if (mem_hit) choice = half_pick;
            end
        end
    end
endmodule

// File: rtl/hb_timing_mux.sv
module hb_timing_mux
    import hb_dcs_pkg::*;
(
    input  cs_choice_t     choice,
    input  logic           dual,
    input  logic           own_timing,
    input  logic           is_write,
    input  timing_prof_t   prof0,
    input  timing_prof_t   prof1,
    output access_timing_t timing
);
    timing_prof_t picked;

    always_comb begin
        picked = (choice == CS_ONE && dual && own_timing) ? prof1 : prof0;
        if (choice == CS_NONE) begin
            timing = '0;
        end else begin
            timing.clkdiv   = picked.clkdiv;
            timing.wait_cnt = is_write ? picked.wr_ws : picked.rd_ws;
            timing.strb_pol = picked.strb_pol;
        end
    end
endmodule

// File: rtl/hb_dcs_decoder.sv
module hb_dcs_decoder
    import hb_dcs_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int WIN_W     = 4,
    parameter int SEL_W     = 2,
    parameter int PERI_BASE = 10,
    parameter int MEM_BASE  = 6,
    localparam int OFF_W    = ADDR_W - WIN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic              acc_write,
    input  logic [2:0]        cs_mode,
    input  logic [SEL_W-1:0]  peri_sel,
    input  logic [SEL_W-1:0]  mem_sel,
    input  logic              cs_own_timing,
    input  logic [DIV_W-1:0]  t0_clkdiv,
    input  logic [WS_W-1:0]   t0_rd_ws,
    input  logic [WS_W-1:0]   t0_wr_ws,
    input  logic              t0_strb_pol,
    input  logic [DIV_W-1:0]  t1_clkdiv,
    input  logic [WS_W-1:0]   t1_rd_ws,
    input  logic [WS_W-1:0]   t1_wr_ws,
    input  logic              t1_strb_pol,
    output logic              cs0_n,
    output logic              cs1_n,
    output logic              hit,
    output logic [OFF_W-1:0]  ext_addr,
    output logic [DIV_W-1:0]  prof_clkdiv,
    output logic [WS_W-1:0]   prof_wait,
    output logic              prof_strb_pol
);
    localparam int                 NREG      = 2;
    localparam logic [OFF_W-1:0]   MASK_FULL = '1;
    localparam logic [OFF_W-1:0]   MASK_M2   = MASK_FULL >> 1;
    localparam logic [OFF_W-1:0]   MASK_M3   = MASK_FULL >> 2;

    logic [WIN_W-1:0] win;
    logic [OFF_W-1:0] offset;
    logic [OFF_W-1:0] addr_mask;
    logic             dual;
    logic [NREG-1:0]  reg_en;
    logic [NREG-1:0]  reg_hit;
    logic [SEL_W-1:0] reg_sel [NREG];

    cs_choice_t     choice;
    timing_prof_t   prof0, prof1;
    access_timing_t acc_t;
    access_timing_t acc_t_q;

    assign win        = addr[ADDR_W-1 -: WIN_W];
    assign offset     = addr[OFF_W-1:0];
    assign dual       = mode_is_dual(cs_mode);
    assign reg_sel[0] = peri_sel;
    assign reg_sel[1] = mem_sel;

    // region 0 is the peripheral window, region 1 the memory window
    for (genvar g = 0; g < NREG; g++) begin : g_region
        hb_region_match #(
            .WIN_W    (WIN_W),
            .SEL_W    (SEL_W),
            .WIN_BASE ((g == 0) ? PERI_BASE : MEM_BASE)
        ) i_match (
            .win     (win),
            .sel     (reg_sel[g]),
            .enabled (reg_en[g]),
            .match   (reg_hit[g])
        );
    end

    hb_cs_select i_select (
        .valid     (addr_valid),
        .dual      (dual),
        .peri_en   (reg_en[0]),
        .mem_en    (reg_en[1]),
        .peri_hit  (reg_hit[0]),
        .mem_hit   (reg_hit[1]),
        .split_bit (offset[OFF_W-1]),
        .choice    (choice)
    );

    always_comb begin
        prof0 = '{clkdiv: t0_clkdiv, rd_ws: t0_rd_ws, wr_ws: t0_wr_ws, strb_pol: t0_strb_pol};
        prof1 = '{clkdiv: t1_clkdiv, rd_ws: t1_rd_ws, wr_ws: t1_wr_ws, strb_pol: t1_strb_pol};
    end

    hb_timing_mux i_timing (
        .choice     (choice),
        .dual       (dual),
        .own_timing (cs_own_timing),
        .is_write   (acc_write),
        .prof0      (prof0),
        .prof1      (prof1),
        .timing     (acc_t)
    );

    always_comb begin
        case (cs_mode)
            3'd2:    addr_mask = MASK_M2;
            3'd3:    addr_mask = MASK_M3;
            default: addr_mask = MASK_FULL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs0_n    <= 1'b1;
            cs1_n    <= 1'b1;
            hit      <= 1'b0;
            ext_addr <= '0;
            acc_t_q  <= '0;
        end else begin
            cs0_n    <= (choice != CS_ZERO);
            cs1_n    <= (choice != CS_ONE);
            hit      <= (choice != CS_NONE);
            ext_addr <= (choice != CS_NONE) ? (offset & addr_mask) : '0;
            acc_t_q  <= acc_t;
        end
    end

    assign prof_clkdiv   = acc_t_q.clkdiv;
    assign prof_wait     = acc_t_q.wait_cnt;
    assign prof_strb_pol = acc_t_q.strb_pol;

    AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(!cs0_n && !cs1_n)); // R8
    AST_HIT_TRACKS_CS: assert property (@(posedge clk) disable iff (rst) hit == (!cs0_n || !cs1_n)); // R8
    AST_IDLE_NO_SELECT: assert property (@(posedge clk) disable iff (rst) !addr_valid |=> (!hit && cs0_n && cs1_n)); // R2
    AST_SINGLE_CS0_ONLY: assert property (@(posedge clk) disable iff (rst) (addr_valid && cs_mode != 3'd2 && cs_mode != 3'd3) |=> cs1_n); // R3
    AST_NO_REGION_NO_HIT: assert property (@(posedge clk) disable iff (rst) (addr_valid && peri_sel == '0 && mem_sel == '0) |=> !hit); // R7
    AST_SHARED_TIMING: assert property (@(posedge clk) disable iff (rst) (addr_valid && !cs_own_timing) |=> (!hit || prof_clkdiv == $past(t0_clkdiv))); // R9
endmodule

// File: tb/test_hb_dcs_decoder.sv
module test_hb_dcs_decoder;
    import hb_dcs_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    localparam logic [7:0] T0_DIV = 8'h03;
    localparam logic [1:0] T0_RD  = 2'd1;
    localparam logic [1:0] T0_WR  = 2'd2;
    localparam logic       T0_POL = 1'b0;
    localparam logic [7:0] T1_DIV = 8'h11;
    localparam logic [1:0] T1_RD  = 2'd3;
    localparam logic [1:0] T1_WR  = 2'd0;
    localparam logic       T1_POL = 1'b1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        addr_valid = 1'b0;
    logic [31:0] addr = '0;
    logic        acc_write = 1'b0;
    logic [2:0]  cs_mode = '0;
    logic [1:0]  peri_sel = '0;
    logic [1:0]  mem_sel = '0;
    logic        cs_own_timing = 1'b0;
    logic        cs0_n, cs1_n, hit, prof_strb_pol;
    logic [27:0] ext_addr;
    logic [7:0]  prof_clkdiv;
    logic [1:0]  prof_wait;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hb_dcs_decoder i_hb_dcs_decoder (
        .clk (clk), .rst (rst), .addr_valid (addr_valid), .addr (addr),
        .acc_write (acc_write), .cs_mode (cs_mode), .peri_sel (peri_sel),
        .mem_sel (mem_sel), .cs_own_timing (cs_own_timing),
        .t0_clkdiv (T0_DIV), .t0_rd_ws (T0_RD), .t0_wr_ws (T0_WR), .t0_strb_pol (T0_POL),
        .t1_clkdiv (T1_DIV), .t1_rd_ws (T1_RD), .t1_wr_ws (T1_WR), .t1_strb_pol (T1_POL),
        .cs0_n (cs0_n), .cs1_n (cs1_n), .hit (hit), .ext_addr (ext_addr),
        .prof_clkdiv (prof_clkdiv), .prof_wait (prof_wait), .prof_strb_pol (prof_strb_pol)
    );

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [2:0] m, input logic [1:0] ps, input logic [1:0] ms, input logic own);
        @(negedge clk);
        cs_mode = m; peri_sel = ps; mem_sel = ms; cs_own_timing = own;
    endtask

    // target: 0 = none, 1 = cs0, 2 = cs1; prof: 0 or 1
    task automatic access(input logic [31:0] a, input logic wr, input int target, input int prof, input string req);
        logic [27:0] mask;
        logic [27:0] exp_addr;
        logic [7:0]  exp_div;
        logic [1:0]  exp_wait;
        logic        exp_pol;
        @(negedge clk);
        addr = a; acc_write = wr; addr_valid = 1'b1;
        @(posedge clk);
        #1;
        mask = (cs_mode == 3'd2) ? 28'h7FF_FFFF : (cs_mode == 3'd3) ? 28'h3FF_FFFF : 28'hFFF_FFFF;
        exp_addr = (target != 0) ? (a[27:0] & mask) : '0;
        exp_div  = (target == 0) ? 8'h00 : (prof == 1) ? T1_DIV : T0_DIV;
        exp_pol  = (target == 0) ? 1'b0 : (prof == 1) ? T1_POL : T0_POL;
        if (target == 0) exp_wait = '0;
        else if (prof == 1) exp_wait = wr ? T1_WR : T1_RD;
        else exp_wait = wr ? T0_WR : T0_RD;
        check(req, "cs0_n", 64'(cs0_n), 64'(target != 1));
        check(req, "cs1_n", 64'(cs1_n), 64'(target != 2));
        check(req, "hit", 64'(hit), 64'(target != 0));
        check("R8", "exclusive", 64'(!cs0_n && !cs1_n), 64'(0));
        check("R11", "ext_addr", 64'(ext_addr), 64'(exp_addr));
        check("R9", "prof_clkdiv", 64'(prof_clkdiv), 64'(exp_div));
        check("R9", "prof_strb_pol", 64'(prof_strb_pol), 64'(exp_pol));
        check("R10", "prof_wait", 64'(prof_wait), 64'(exp_wait));
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1", "cs0_n", 64'(cs0_n), 64'(1));
        check("R1", "cs1_n", 64'(cs1_n), 64'(1));
        check("R1", "hit", 64'(hit), 64'(0));
        check("R1", "ext_addr", 64'(ext_addr), 64'(0));
        check("R1", "profile", 64'({prof_clkdiv, prof_wait, prof_strb_pol}), 64'(0));
    endtask

    task automatic t_single;
        set_cfg(3'd0, 2'd1, 2'd2, 1'b1);
        access(32'hA800_0010, 1'b0, 1, 0, "R3");
        access(32'h7000_0020, 1'b1, 1, 0, "R3");
        set_cfg(3'd5, 2'd1, 2'd2, 1'b1);
        access(32'h7C00_0004, 1'b0, 1, 0, "R3");
        access(32'hB000_0000, 1'b0, 0, 0, "R2");
    endtask

    task automatic t_dual_peri_split;
        set_cfg(3'd2, 2'd1, 2'd0, 1'b1);
        access(32'hA000_0010, 1'b0, 1, 0, "R4");
        access(32'hA800_0010, 1'b0, 2, 1, "R4");
        access(32'hA800_0010, 1'b1, 2, 1, "R10");
        access(32'h7000_0020, 1'b0, 0, 0, "R7");
    endtask

    task automatic t_dual_mem_split;
        set_cfg(3'd3, 2'd0, 2'd2, 1'b1);
        access(32'h7000_0020, 1'b1, 1, 0, "R5");
        access(32'h7C00_0004, 1'b1, 2, 1, "R5");
        access(32'h7FFF_FFFF, 1'b0, 2, 1, "R11");
        access(32'hA000_0000, 1'b0, 0, 0, "R7");
    endtask

    task automatic t_dual_both;
        set_cfg(3'd2, 2'd3, 2'd1, 1'b1);
        access(32'hC800_0000, 1'b0, 1, 0, "R6");
        access(32'h6000_0000, 1'b0, 2, 1, "R6");
        access(32'h6800_0040, 1'b1, 2, 1, "R6");
        access(32'hA000_0000, 1'b0, 0, 0, "R2");
    endtask

    task automatic t_shared_timing;
        set_cfg(3'd2, 2'd1, 2'd0, 1'b0);
        access(32'hA800_0010, 1'b0, 2, 0, "R9");
        access(32'hA800_0010, 1'b1, 2, 0, "R9");
    endtask

    task automatic t_miss_and_disabled;
        set_cfg(3'd2, 2'd1, 2'd1, 1'b1);
        access(32'h3000_0000, 1'b0, 0, 0, "R7");
        set_cfg(3'd2, 2'd0, 2'd0, 1'b1);
        access(32'hA000_0000, 1'b0, 0, 0, "R7");
        access(32'h6000_0000, 1'b0, 0, 0, "R7");
    endtask

    task automatic t_idle;
        set_cfg(3'd0, 2'd1, 2'd0, 1'b0);
        access(32'hA000_0100, 1'b0, 1, 0, "R2");
        @(negedge clk);
        addr_valid = 1'b0;
        @(posedge clk);
        #1;
        check("R2", "idle hit", 64'(hit), 64'(0));
        check("R2", "idle cs", 64'({cs0_n, cs1_n}), 64'(2'b11));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset;
        @(negedge clk);
        rst = 1'b0;
        t_single;
        t_dual_peri_split;
        t_dual_mem_split;
        t_dual_both;
        t_shared_timing;
        t_miss_and_disabled;
        t_idle;
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired after %0d cycles", cyc);
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule